// File: doc/BRIEF.md
# Multi-operand sum-of-products unit

This unit is a purely combinational datapath that forms `a*b + c*d + e + f` over six unsigned operands of `W` bits each. It is meant to sit inside a larger arithmetic pipeline, where the surrounding stages register its inputs and output. It has no clock and no reset. A new operand set produces a settled result within the same cycle.

The datapath has three parts. Two AND arrays form the partial-product bits of both products. A column-compression tree then takes those bits, plus the bits of the two plain addends, and reduces every column to at most two bits. A ripple carry-propagate adder adds the two remaining rows.

The tree works through the columns from the least significant to the most significant. Before a column is reduced, every carry that lower columns send into it is already in its list. While a column still holds three or more bits, the tree takes four of them through a 4-input, 3-output counter whenever it can, and otherwise takes three through a full adder. The 4-input counter's top output goes straight to the column two places up. The half adder appears once, at bit 0 of the final adder.

Top module: `sop_unit`

## Requirements
- R1: `result` equals `mul_a*mul_b + mul_c*mul_d + add_e + add_f` computed on unsigned values, for every combination of operand values.
- R2: `result` is `2*W+1` bits wide (17 for `W`=8), and the largest possible sum, 130560 when every operand is 255, comes out exactly without wrapping.
- R3: After compression, every column holds at most two bits, and the two remaining rows carry the full arithmetic weight of all partial products and addend bits.
- R4: The 4:3 counter returns three bits. The column-i bit is the XOR of its four inputs. The column-(i+1) bit is high when exactly two or three inputs are high. The column-(i+2) bit is the AND of all four. The weighted value s + 2*c1 + 4*c2 equals the number of high inputs.
- R5: The 3:2 counter and the 2:2 counter each return `{carry, sum}`, where 2*carry + sum equals the number of high inputs.
- R6: No bit reaches a column at or above `2*W+1`, and the final adder produces no carry out, for any inputs.
- R7: When `mul_a` or `mul_b` is zero, the first product contributes nothing and `result` equals `mul_c*mul_d + add_e + add_f`. The same holds symmetrically for `mul_c` or `mul_d` and the second product.
- R8: With all four multiplicand inputs at zero, `result` equals `add_e + add_f`, including the case where both addends are all ones (510).
- R9: `result` settles from the operand inputs alone. An operand change applied between clock edges is visible before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | W (8) | First factor of the first product |
| mul_b | input | W (8) | Second factor of the first product |
| mul_c | input | W (8) | First factor of the second product |
| mul_d | input | W (8) | Second factor of the second product |
| add_e | input | W (8) | First plain addend |
| add_f | input | W (8) | Second plain addend |
| result | output | 2*W+1 (17) | Unsigned sum of both products and both addends |

## Verification
The bench sweeps both factor pairs exhaustively, each with its partner operands tied to related values, so that every column height and every carry pattern in the tree is reached. A dropped or misrouted two-column carry from a 4:3 counter shows up as a result off by a multiple of a power of two on exactly those sweeps.

The all-ones vector fills the tallest middle columns and drives the top bit. A tree that lost weight, left a third bit in a column, or truncated the output would return a value below 130560 there.

Zero factors, addend-only inputs and a mid-cycle operand change target, in turn, a product term leaking into the sum, wrong placement of the addend bits in the low columns, and an accidental registered stage. Exhaustive checks of the three counter functions catch a wrong popcount bit before it can hide among multi-column errors.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  typedef struct packed {
    logic c2;  // weight 4, column i+2
    logic c1;  // weight 2, column i+1
    logic s;   // weight 1, column i
  } cnt43_t;

  // two bits of one column -> {carry, sum}
  function automatic logic [1:0] cnt22(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction

  // three bits of one column -> {carry, sum}
  function automatic logic [1:0] cnt32(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

  // four bits of one column -> sum, carry one column up, carry two columns up
  function automatic cnt43_t cnt43(input logic [3:0] v);
    cnt43_t r;
    logic   lo_x;
    logic   hi_x;
    lo_x = v[0] ^ v[1];
    hi_x = v[2] ^ v[3];
    r.s  = lo_x ^ hi_x;
    r.c1 = (v[0] & v[1]) ^ (v[2] & v[3]) ^ (lo_x & hi_x);
    r.c2 = &v;
    return r;
  endfunction

endpackage

// File: rtl/sop_ppgen.sv
`timescale 1ns/1ps
module sop_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]         mul_x,
  input  logic [W-1:0]         mul_y,
  output logic [W-1:0][W-1:0]  pp
);

  // row j holds mul_x gated by bit j of mul_y; bit i of row j has weight i+j
  for (genvar j = 0; j < W; j++) begin : g_row
    assign pp[j] = mul_x & {W{mul_y[j]}};
  end

endmodule

// File: rtl/sop_tree.sv
`timescale 1ns/1ps
module sop_tree #(
  parameter int W     = 8,
  parameter int OUT_W = 2*W + 1,
  parameter int CAP   = 8*W
) (
  input  logic [W-1:0][W-1:0] pp_ab,
  input  logic [W-1:0][W-1:0] pp_cd,
  input  logic [W-1:0]        add_e,
  input  logic [W-1:0]        add_f,
  output logic [OUT_W-1:0]    row_lo,
  output logic [OUT_W-1:0]    row_hi,
  output logic                spill
);

  localparam int NCOLX = OUT_W + 2;          // two guard columns catch any stray carry
  localparam int CW    = $clog2(NCOLX);
  localparam int IW    = $clog2(CAP);
  localparam int WB    = (W > 1) ? $clog2(W) : 1;
  localparam int OB    = $clog2(OUT_W);

  always_comb begin : p_reduce
    logic          elem [NCOLX][CAP];
    int            tl   [NCOLX];
    int            hd;
    int            col;
    sop_pkg::cnt43_t q4;
    logic [1:0]    q3;
    logic          lost;

    hd     = 0;
    col    = 0;
    q4     = '0;
    q3     = '0;
    lost   = 1'b0;
    row_lo = '0;
    row_hi = '0;
    spill  = 1'b0;

    for (int c = 0; c < NCOLX; c++) begin
      tl[CW'(c)] = 0;
      for (int k = 0; k < CAP; k++) begin
        elem[CW'(c)][IW'(k)] = 1'b0;
      end
    end

    // load partial products of both arrays into their weight columns
    for (int j = 0; j < W; j++) begin
      for (int i = 0; i < W; i++) begin
        col = i + j;
        elem[CW'(col)][IW'(tl[CW'(col)])] = pp_ab[WB'(j)][WB'(i)];
        tl[CW'(col)] = tl[CW'(col)] + 1;
        elem[CW'(col)][IW'(tl[CW'(col)])] = pp_cd[WB'(j)][WB'(i)];
        tl[CW'(col)] = tl[CW'(col)] + 1;
      end
    end

    // plain addends enter as single bits in their own columns
    for (int i = 0; i < W; i++) begin
      elem[CW'(i)][IW'(tl[CW'(i)])] = add_e[WB'(i)];
      tl[CW'(i)] = tl[CW'(i)] + 1;
      elem[CW'(i)][IW'(tl[CW'(i)])] = add_f[WB'(i)];
      tl[CW'(i)] = tl[CW'(i)] + 1;
    end

    // column walk, LSB first: all incoming carries are present before a column is reduced
    for (int i = 0; i < OUT_W; i++) begin
      hd = 0;
      for (int s = 0; s < CAP; s++) begin
        if (tl[CW'(i)] - hd >= 4) begin
          q4 = sop_pkg::cnt43({elem[CW'(i)][IW'(hd+3)], elem[CW'(i)][IW'(hd+2)],
                               elem[CW'(i)][IW'(hd+1)], elem[CW'(i)][IW'(hd)]});
          hd = hd + 4;
          if (tl[CW'(i)] < CAP) begin
            elem[CW'(i)][IW'(tl[CW'(i)])] = q4.s;
            tl[CW'(i)] = tl[CW'(i)] + 1;
          end else begin
            lost = 1'b1;
          end
          if (tl[CW'(i+1)] < CAP) begin
            elem[CW'(i+1)][IW'(tl[CW'(i+1)])] = q4.c1;
            tl[CW'(i+1)] = tl[CW'(i+1)] + 1;
          end else begin
            lost = 1'b1;
          end
          if (tl[CW'(i+2)] < CAP) begin
            elem[CW'(i+2)][IW'(tl[CW'(i+2)])] = q4.c2;
            tl[CW'(i+2)] = tl[CW'(i+2)] + 1;
          end else begin
            lost = 1'b1;
          end
        end else if (tl[CW'(i)] - hd == 3) begin
          q3 = sop_pkg::cnt32(elem[CW'(i)][IW'(hd)], elem[CW'(i)][IW'(hd+1)],
                              elem[CW'(i)][IW'(hd+2)]);
          hd = hd + 3;
          if (tl[CW'(i)] < CAP) begin
            elem[CW'(i)][IW'(tl[CW'(i)])] = q3[0];
            tl[CW'(i)] = tl[CW'(i)] + 1;
          end else begin
            lost = 1'b1;
          end
          if (tl[CW'(i+1)] < CAP) begin
            elem[CW'(i+1)][IW'(tl[CW'(i+1)])] = q3[1];
            tl[CW'(i+1)] = tl[CW'(i+1)] + 1;
          end else begin
            lost = 1'b1;
          end
        end
      end
      if (tl[CW'(i)] - hd >= 1) row_lo[OB'(i)] = elem[CW'(i)][IW'(hd)];
      if (tl[CW'(i)] - hd >= 2) row_hi[OB'(i)] = elem[CW'(i)][IW'(hd+1)];
      if (tl[CW'(i)] - hd >  2) lost = 1'b1;
    end

    // anything that landed above the output width is reported, not kept
    for (int c = OUT_W; c < NCOLX; c++) begin
      for (int k = 0; k < CAP; k++) begin
        if (k < tl[CW'(c)]) spill = spill | elem[CW'(c)][IW'(k)];
      end
    end
    spill = spill | lost;
  end

endmodule

// File: rtl/sop_cpa.sv
`timescale 1ns/1ps
module sop_cpa #(
  parameter int OUT_W = 17
) (
  input  logic [OUT_W-1:0] opnd_x,
  input  logic [OUT_W-1:0] opnd_y,
  output logic [OUT_W-1:0] sum,
  output logic             cout
);

  logic [OUT_W:1] cy;

  for (genvar g = 0; g < OUT_W; g++) begin : g_bit
    if (g == 0) begin : g_half
      assign {cy[1], sum[0]} = sop_pkg::cnt22(opnd_x[0], opnd_y[0]);
    end else begin : g_full
      assign {cy[g+1], sum[g]} = sop_pkg::cnt32(opnd_x[g], opnd_y[g], cy[g]);
    end
  end

  assign cout = cy[OUT_W];

endmodule

// File: rtl/sop_unit.sv
`timescale 1ns/1ps
module sop_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mul_a,
  input  logic [W-1:0]   mul_b,
  input  logic [W-1:0]   mul_c,
  input  logic [W-1:0]   mul_d,
  input  logic [W-1:0]   add_e,
  input  logic [W-1:0]   add_f,
  output logic [2*W:0]   result
);

  localparam int OUT_W = 2*W + 1;

  logic [W-1:0][W-1:0] pp_ab;
  logic [W-1:0][W-1:0] pp_cd;
  logic [OUT_W-1:0]    row_lo;
  logic [OUT_W-1:0]    row_hi;
  logic                tree_spill;
  logic                cpa_cout;

  sop_ppgen #(.W(W)) u_ppg_ab (
    .mul_x (mul_a),
    .mul_y (mul_b),
    .pp    (pp_ab)
  );

  sop_ppgen #(.W(W)) u_ppg_cd (
    .mul_x (mul_c),
    .mul_y (mul_d),
    .pp    (pp_cd)
  );

  sop_tree #(.W(W), .OUT_W(OUT_W)) u_tree (
    .pp_ab  (pp_ab),
    .pp_cd  (pp_cd),
    .add_e  (add_e),
    .add_f  (add_f),
    .row_lo (row_lo),
    .row_hi (row_hi),
    .spill  (tree_spill)
  );

  sop_cpa #(.OUT_W(OUT_W)) u_cpa (
    .opnd_x (row_lo),
    .opnd_y (row_hi),
    .sum    (result),
    .cout   (cpa_cout)
  );

endmodule

module sop_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   mul_a,
  input logic [W-1:0]   mul_b,
  input logic [W-1:0]   mul_c,
  input logic [W-1:0]   mul_d,
  input logic [W-1:0]   add_e,
  input logic [W-1:0]   add_f,
  input logic [2*W:0]   result,
  input logic [2*W:0]   row_lo,
  input logic [2*W:0]   row_hi,
  input logic           tree_spill,
  input logic           cpa_cout
);

  localparam int unsigned MAXV = 2 * ((32'd1 << W) - 1) * (32'd1 << W);

  int unsigned exp_ab;
  int unsigned exp_rest;
  int unsigned exp_all;

  always_comb begin
    exp_ab   = 32'(mul_a) * 32'(mul_b);
    exp_rest = 32'(mul_c) * 32'(mul_d) + 32'(add_e) + 32'(add_f);
    exp_all  = exp_ab + exp_rest;
    if (!$isunknown({mul_a, mul_b, mul_c, mul_d, add_e, add_f, result, row_lo, row_hi,
                     tree_spill, cpa_cout})) begin
      p_result_r1: assert (32'(result) == exp_all)
        else $error("sum mismatch %0d vs %0d", result, exp_all);
      p_bound_r2: assert (32'(result) <= MAXV)
        else $error("result %0d above the largest reachable sum", result);
      p_rows_value_r3: assert (32'(row_lo) + 32'(row_hi) == exp_all)
        else $error("compressed rows lost weight");
      p_no_spill_r6: assert (!tree_spill && !cpa_cout)
        else $error("carry escaped above the output width");
      if (mul_a == '0 || mul_b == '0) begin
        p_zero_prod_r7: assert (32'(result) == exp_rest)
          else $error("vanished product still contributes");
      end
    end
  end

endmodule

bind sop_unit sop_unit_chk #(.W(W)) u_chk (
  .mul_a      (mul_a),
  .mul_b      (mul_b),
  .mul_c      (mul_c),
  .mul_d      (mul_d),
  .add_e      (add_e),
  .add_f      (add_f),
  .result     (result),
  .row_lo     (row_lo),
  .row_hi     (row_hi),
  .tree_spill (tree_spill),
  .cpa_cout   (cpa_cout)
);

// File: tb/test_sop_unit.sv
`timescale 1ns/1ps
module test_sop_unit;

  localparam int WD_LIMIT = 190000;

  logic        clk;
  logic        rst_n;
  logic [7:0]  s_a, s_b, s_c, s_d, s_e, s_f;
  logic [16:0] s_z;
  int          n_run;
  int          n_fail;
  int          cyc;

  sop_unit #(.W(8)) i_sop_unit (
    .mul_a  (s_a),
    .mul_b  (s_b),
    .mul_c  (s_c),
    .mul_d  (s_d),
    .add_e  (s_e),
    .add_f  (s_f),
    .result (s_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL R9 watchdog: actual=still running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int unsigned model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c, input logic [7:0] d,
                                        input logic [7:0] e, input logic [7:0] f);
    return 32'(a) * 32'(b) + 32'(c) * 32'(d) + 32'(e) + 32'(f);
  endfunction

  task automatic compare(input string rq, input int unsigned exp_v);
    n_run = n_run + 1;
    if (32'(s_z) != exp_v) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: a=%0d b=%0d c=%0d d=%0d e=%0d f=%0d actual=%0d expected=%0d",
               rq, s_a, s_b, s_c, s_d, s_e, s_f, s_z, exp_v);
    end
  endtask

  task automatic run_vec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input logic [7:0] d, input logic [7:0] e, input logic [7:0] f,
                         input string rq);
    @(posedge clk);
    {s_a, s_b, s_c, s_d, s_e, s_f} = {a, b, c, d, e, f};
    @(negedge clk);
    compare(rq, model(a, b, c, d, e, f));
  endtask

  initial begin
    sop_pkg::cnt43_t r4;
    logic [1:0]      r2;
    n_run  = 0;
    n_fail = 0;
    cyc    = 0;
    rst_n  = 1'b0;
    {s_a, s_b, s_c, s_d, s_e, s_f} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset-state zero", 0);
    rst_n = 1'b1;

    // R4: 4:3 counter, every input pattern
    for (int v = 0; v < 16; v++) begin
      r4 = sop_pkg::cnt43(4'(v));
      n_run = n_run + 1;
      if (32'(r4.s) + 2*32'(r4.c1) + 4*32'(r4.c2) != $countones(4'(v)) ||
          r4.c2 != (v == 15) || r4.s != ^4'(v)) begin
        n_fail = n_fail + 1;
        $display("FAIL R4: in=%b actual=%b expected weight %0d", 4'(v), r4, $countones(4'(v)));
      end
    end
    // R5: 3:2 and 2:2 counters
    for (int v = 0; v < 8; v++) begin
      r2 = sop_pkg::cnt32(v[0], v[1], v[2]);
      n_run = n_run + 1;
      if (2*32'(r2[1]) + 32'(r2[0]) != $countones(3'(v))) begin
        n_fail = n_fail + 1;
        $display("FAIL R5 3:2: in=%b actual=%b expected weight %0d", 3'(v), r2, $countones(3'(v)));
      end
    end
    for (int v = 0; v < 4; v++) begin
      r2 = sop_pkg::cnt22(v[0], v[1]);
      n_run = n_run + 1;
      if (2*32'(r2[1]) + 32'(r2[0]) != $countones(2'(v))) begin
        n_fail = n_fail + 1;
        $display("FAIL R5 2:2: in=%b actual=%b expected weight %0d", 2'(v), r2, $countones(2'(v)));
      end
    end

    // corners
    run_vec(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R2,R3,R6 all ones");
    run_vec(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R1 all zeros");
    run_vec(8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R7 a zero");
    run_vec(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R7 b zero");
    run_vec(8'hFF, 8'hFF, 8'h00, 8'hA5, 8'h01, 8'h80, "R7 c zero");
    run_vec(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, "R8 addends max");
    run_vec(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, "R8 single low bit");
    run_vec(8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80, "R8 top bits");
    run_vec(8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00, "R3 top partial products");

    // R9: change between edges, sample before the next edge
    @(negedge clk);
    {s_a, s_b, s_c, s_d, s_e, s_f} = {8'd200, 8'd13, 8'd77, 8'd255, 8'd9, 8'd250};
    #3;
    compare("R9 mid-cycle change", model(8'd200, 8'd13, 8'd77, 8'd255, 8'd9, 8'd250));

    // first product swept exhaustively
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        run_vec(8'(x), 8'(y), 8'(x) ^ 8'h5A, 8'(y) + 8'd3, 8'(x), ~8'(y), "R1 sweep ab");
      end
    end
    // second product swept exhaustively
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        run_vec(~8'(x), 8'(y) ^ 8'hC3, 8'(x), 8'(y), 8'(y), 8'(x), "R1 sweep cd");
      end
    end
    // random operands
    for (int n = 0; n < 4000; n++) begin
      run_vec(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), "R1 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule